// File: doc/BRIEF.md
# Address-Decoded Read/Write Interconnect

This block joins one requester to a set of memory-mapped regions through plain combinational logic. The requester supplies an address and a write strobe. Each region supplies its own read-data word. The block works out which region the address falls in. It then returns that region's data on the shared read path and steers the write strobe to that region alone.

Each region is fixed at elaboration by two values. The first is a base address. The second is a span, given as a count of low address bits, so every region covers an aligned window whose size is a power of two. A single decode produces both the read-data select and the per-region write enables, so the two can never disagree. An address that hits no region reads as zero and writes nowhere. If the parameters make regions overlap, the region with the lowest index takes the access.

Top module: `mmap_bus_decode`

## Requirements
- R1: Region i matches when the address bits at and above position SPAN_i equal the same bits of BASE_i. The low SPAN_i bits of the address, and of the base, take no part in the match.
- R2: When region i is selected, rd_data_o equals slice i of rd_bus_i, which is bits [i*DATA_W +: DATA_W].
- R3: rd_data_o depends only on the address and rd_bus_i. Changing wr_i never alters it.
- R4: Bit i of wr_en_o is 1 exactly when wr_i is 1 and region i is selected. At most one bit of wr_en_o is ever 1.
- R5: When no region matches, rd_data_o is zero and every bit of wr_en_o is 0, whatever the value of wr_i.
- R6: When several regions match the same address, only the lowest-indexed one is selected, for both the read path and the write enables.
- R7: The block holds no state. Both outputs follow an input change without any clock edge.
- R8: A region with span 0 covers exactly the single address equal to its base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | ADDR_W | Requester address |
| wr_i | input | 1 | Requester write strobe |
| rd_bus_i | input | N_REGIONS*DATA_W | Read data of all regions, region i at bits [i*DATA_W +: DATA_W] |
| rd_data_o | output | DATA_W | Read data of the selected region, or zero on a miss |
| wr_en_o | output | N_REGIONS | Write enable per region, bit i for region i |

## Verification
The bench builds the block with five regions. These are an 8-address window at 0x00, a 4-address window declared at base 0x0A, a 16-address window at 0x80, a 4-address window at 0x88 that lies inside the 0x80 window, and a single-address window at 0x42. Because the second base is declared at 0x0A, the test shows that the base's low bits are ignored. The nested window at 0x88 makes the lowest-index priority visible on both the read path and the write path. The single-address window reaches the zero-span case, and the gaps between the windows give misses on both sides of every boundary.

// File: rtl/mmap_bus_pkg.sv
package mmap_bus_pkg;

   // width of one span entry in the packed span parameter
   localparam int unsigned SPAN_W = 8;

   typedef logic [SPAN_W-1:0] span_t;

   // largest address width the decode accepts
   localparam int unsigned MAX_ADDR_W = 32;

endpackage

// File: rtl/mmap_region_match.sv
module mmap_region_match
   import mmap_bus_pkg::*;
#(
   parameter int unsigned          ADDR_W = 8,
   parameter logic [ADDR_W-1:0]    BASE   = '0,
   parameter span_t                SPAN   = span_t'(0)
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);

   // bits at or above SPAN take part in the compare
   function automatic logic [ADDR_W-1:0] upper_mask();
      logic [ADDR_W-1:0] m;
      for (int b = 0; b < ADDR_W; b++) begin
         m[b] = (b >= int'(SPAN));
      end
      return m;
   endfunction

   localparam logic [ADDR_W-1:0] KEEP   = upper_mask();
   localparam logic [ADDR_W-1:0] WIN_LO = BASE & KEEP;
   localparam logic [ADDR_W-1:0] WIN_HI = WIN_LO | ~KEEP;

   generate
      if (int'(SPAN) > ADDR_W) begin : g_bad_span
         $error("mmap_region_match: span exceeds address width");
      end
   endgenerate

   assign hit_o = ((addr_i ^ BASE) & KEEP) == '0;

   // the hit must agree with an arithmetic window check (R1)
   always_comb begin
      p_window_r1: assert (hit_o == ((addr_i >= WIN_LO) && (addr_i <= WIN_HI)))
         else $error("region hit disagrees with window bounds");
   end

endmodule

// File: rtl/mmap_first_hit.sv
module mmap_first_hit #(
   parameter int unsigned N_REGIONS = 2
) (
   input  logic [N_REGIONS-1:0] hit_i,
   output logic [N_REGIONS-1:0] grant_o
);

   // seen[i] is set when some region below index i already matched
   logic [N_REGIONS:0] seen;

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < N_REGIONS; i++) begin : g_chain
         assign seen[i+1]  = seen[i] | hit_i[i];
         assign grant_o[i] = hit_i[i] & ~seen[i];
      end
   endgenerate

   always_comb begin
      p_single_grant_r6: assert ($onehot0(grant_o))
         else $error("more than one region granted");
      p_grant_subset_r6: assert ((grant_o & ~hit_i) == '0)
         else $error("grant on a region that did not match");
      p_grant_any_r6: assert ((|grant_o) == (|hit_i))
         else $error("a match was dropped or invented");
   end

endmodule

// File: rtl/mmap_read_mux.sv
module mmap_read_mux #(
   parameter int unsigned N_REGIONS = 2,
   parameter int unsigned DATA_W    = 8
) (
   input  logic [N_REGIONS-1:0]        sel_i,
   input  logic [N_REGIONS*DATA_W-1:0] bus_i,
   output logic [DATA_W-1:0]           data_o
);

   // AND-OR selection: a zero select yields zero data
   always_comb begin
      data_o = '0;
      for (int i = 0; i < N_REGIONS; i++) begin
         data_o = data_o | ({DATA_W{sel_i[i]}} & bus_i[i*DATA_W +: DATA_W]);
      end
   end

   always_comb begin
      if (sel_i == '0) begin
         p_idle_zero_r5: assert (data_o == '0)
            else $error("read data not zero with no select");
      end
   end

endmodule

// File: rtl/mmap_bus_decode.sv
module mmap_bus_decode
   import mmap_bus_pkg::*;
#(
   parameter int unsigned                  ADDR_W      = 8,
   parameter int unsigned                  DATA_W      = 8,
   parameter int unsigned                  N_REGIONS   = 2,
   parameter logic [N_REGIONS*ADDR_W-1:0]  REGION_BASE = {8'h08, 8'h00},
   parameter logic [N_REGIONS*SPAN_W-1:0]  REGION_SPAN = {8'd2, 8'd3}
) (
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic                        wr_i,
   input  logic [N_REGIONS*DATA_W-1:0] rd_bus_i,
   output logic [DATA_W-1:0]           rd_data_o,
   output logic [N_REGIONS-1:0]        wr_en_o
);

   generate
      if (N_REGIONS < 1) begin : g_bad_count
         $error("mmap_bus_decode: at least one region required");
      end
      if (ADDR_W < 1 || ADDR_W > MAX_ADDR_W) begin : g_bad_addr
         $error("mmap_bus_decode: address width out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mmap_bus_decode: data width must be positive");
      end
   endgenerate

   logic [N_REGIONS-1:0] hit_vec;
   logic [N_REGIONS-1:0] grant_vec;

   generate
      for (genvar i = 0; i < N_REGIONS; i++) begin : g_region
         mmap_region_match #(
            .ADDR_W (ADDR_W),
            .BASE   (REGION_BASE[i*ADDR_W +: ADDR_W]),
            .SPAN   (span_t'(REGION_SPAN[i*SPAN_W +: SPAN_W]))
         ) match_i (
            .addr_i (addr_i),
            .hit_o  (hit_vec[i])
         );
      end
   endgenerate

   mmap_first_hit #(
      .N_REGIONS (N_REGIONS)
   ) prio_i (
      .hit_i   (hit_vec),
      .grant_o (grant_vec)
   );

   mmap_read_mux #(
      .N_REGIONS (N_REGIONS),
      .DATA_W    (DATA_W)
   ) mux_i (
      .sel_i  (grant_vec),
      .bus_i  (rd_bus_i),
      .data_o (rd_data_o)
   );

   // the same decode gates the write strobe
   assign wr_en_o = grant_vec & {N_REGIONS{wr_i}};

   always_comb begin
      if (!wr_i) begin
         p_no_strobe_r4: assert (wr_en_o == '0)
            else $error("write enable without write strobe");
      end
      p_wr_onehot_r4: assert ($onehot0(wr_en_o))
         else $error("several write enables at once");
      p_wr_in_match_r4: assert ((wr_en_o & ~hit_vec) == '0)
         else $error("write enable on a region that did not match");
      if (hit_vec == '0) begin
         p_miss_quiet_r5: assert (rd_data_o == '0 && wr_en_o == '0)
            else $error("miss produced data or a write enable");
      end
   end

endmodule

// File: tb/mmap_bus_decode_tb_top.sv
`timescale 1ns/1ps
module mmap_bus_decode_tb_top;

   localparam int unsigned AW = 8;
   localparam int unsigned DW = 8;
   localparam int unsigned NR = 5;

   localparam logic [NR*AW-1:0] BASES = {8'h42, 8'h88, 8'h80, 8'h0A, 8'h00};
   localparam logic [NR*8-1:0]  SPANS = {8'd0, 8'd2, 8'd4, 8'd2, 8'd3};

   localparam logic [DW-1:0] D0 = 8'h64;
   localparam logic [DW-1:0] D1 = 8'hC8;
   localparam logic [DW-1:0] D2 = 8'h3C;
   localparam logic [DW-1:0] D3 = 8'hA5;
   localparam logic [DW-1:0] D4 = 8'h17;

   // vector: {addr, wr, expected read data, expected write enables}
   localparam int N_VEC = 18;
   localparam logic [21:0] VEC [N_VEC] = '{
      {8'h00, 1'b0, D0,    5'h00},  // R2 region 0 read
      {8'h00, 1'b1, D0,    5'h01},  // R4 region 0 write
      {8'h07, 1'b1, D0,    5'h01},  // R1 top of region 0
      {8'h08, 1'b0, D1,    5'h00},  // R1 base low bits ignored
      {8'h09, 1'b0, D1,    5'h00},  // R2 region 1 read
      {8'h09, 1'b1, D1,    5'h02},  // R4 region 1 write
      {8'h0B, 1'b1, D1,    5'h02},  // R1 top of region 1
      {8'h0C, 1'b1, 8'h00, 5'h00},  // R5 miss above region 1
      {8'h7F, 1'b1, 8'h00, 5'h00},  // R5 miss below region 2
      {8'h80, 1'b1, D2,    5'h04},  // R4 region 2 write
      {8'h8F, 1'b0, D2,    5'h00},  // R1 top of region 2
      {8'h89, 1'b1, D2,    5'h04},  // R6 overlap, region 2 wins
      {8'h8B, 1'b0, D2,    5'h00},  // R6 overlap read
      {8'h90, 1'b1, 8'h00, 5'h00},  // R5 miss above region 2
      {8'h42, 1'b1, D4,    5'h10},  // R8 single address hit
      {8'h43, 1'b1, 8'h00, 5'h00},  // R8 next address misses
      {8'h41, 1'b0, 8'h00, 5'h00},  // R8 previous address misses
      {8'hFF, 1'b1, 8'h00, 5'h00}   // R5 miss at top
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [AW-1:0]    addr;
   logic             wr;
   logic [NR*DW-1:0] rd_bus;
   logic [DW-1:0]    rd_data;
   logic [NR-1:0]    wr_en;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   mmap_bus_decode #(
      .ADDR_W      (AW),
      .DATA_W      (DW),
      .N_REGIONS   (NR),
      .REGION_BASE (BASES),
      .REGION_SPAN (SPANS)
   ) dut_i (
      .addr_i    (addr),
      .wr_i      (wr),
      .rd_bus_i  (rd_bus),
      .rd_data_o (rd_data),
      .wr_en_o   (wr_en)
   );

   task automatic check(input string tag, input logic [DW-1:0] exp_rd,
                        input logic [NR-1:0] exp_we);
      n_chk++;
      if (rd_data !== exp_rd || wr_en !== exp_we) begin
         n_fail++;
         $display("FAIL %s addr=%02h wr=%0b: rd=%02h we=%05b, expected rd=%02h we=%05b",
                  tag, addr, wr, rd_data, wr_en, exp_rd, exp_we);
      end
   endtask

   task automatic apply(input logic [AW-1:0] a, input logic w);
      @(negedge clk);
      addr = a;
      wr   = w;
      #1;
   endtask

   initial begin
      addr   = '0;
      wr     = 1'b0;
      rd_bus = {D4, D3, D2, D1, D0};
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // reset state: address 0, no write (R2, R4)
      @(negedge clk);
      #1;
      check("R2 reset state", D0, 5'h00);

      for (int v = 0; v < N_VEC; v++) begin
         apply(VEC[v][21:14], VEC[v][13]);
         check($sformatf("vector %0d", v), VEC[v][12:5], VEC[v][4:0]);
      end

      // R3: toggling wr leaves read data unchanged
      apply(8'h81, 1'b0);
      check("R3 wr low", D2, 5'h00);
      #1 wr = 1'b1;
      #1 check("R3 wr high", D2, 5'h04);
      #1 wr = 1'b0;
      #1 check("R3 wr low again", D2, 5'h00);

      // R7: data changes propagate with no clock edge
      @(negedge clk);
      addr = 8'h0A;
      wr   = 1'b0;
      #0.5 rd_bus[1*DW +: DW] = 8'h5A;
      #0.5 check("R7 data follows without clock", 8'h5A, 5'h00);
      #0.5 addr = 8'h03;
      #0.5 check("R7 address follows without clock", D0, 5'h00);

      // R2: each region's slice is routed, with distinct data
      rd_bus = {8'h44, 8'h33, 8'h22, 8'h11, 8'h99};
      apply(8'h05, 1'b1); check("R2 slice 0", 8'h99, 5'h01);
      apply(8'h0A, 1'b1); check("R2 slice 1", 8'h11, 5'h02);
      apply(8'h8A, 1'b1); check("R6 slice 3 hidden", 8'h22, 5'h04);
      apply(8'h42, 1'b0); check("R2 slice 4", 8'h44, 5'h00);

      // R5: a miss ignores even all-ones data
      rd_bus = '1;
      apply(8'h20, 1'b1); check("R5 miss with all-ones data", 8'h00, 5'h00);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule